// File: doc/BRIEF.md
# Miss Holding Register File with Merged Access Slots

This block keeps track of cache misses and dirty evictions that are still in flight, so that the cache array can go on serving hits while a block is being fetched. Each entry tracks one block address. An entry holds a data buffer and a small set of access slots. Each slot records a load or store from the CPU: its instruction number, the word offset inside the block and, for a store, the word to write.

When a miss arrives, its block address is compared against every live entry. A match merges the access into a free slot of that entry and sends no new request. Without a match, the lowest free entry is taken and one fetch request is queued: a shared request if the entry holds only loads, an exclusive request if it holds any store. A dirty eviction takes an entry together with the whole block and issues a writeback request that carries the data. The entry is released when the writeback is acknowledged.

When a fetch response arrives, the block is placed in the entry's buffer. The slots are then retired in the order they were filled, one per cycle. Each store writes its word into the buffer. After the last slot, the merged block is handed to the cache for filling and the entry is freed.

Top module: `mshr_file`

## Requirements
- R1: After reset, `req_valid`, `cpu_valid` and `fill_valid` are low, `resp_ready` is high and every entry is free.
- R2: A miss that matches no live entry takes the lowest free entry, whose index is the `req_id`. It produces exactly one request with `req_kind` 0 (shared) if the entry holds only loads, or 1 (exclusive) if it holds a store. The request is held unchanged while `req_ready` is low.
- R3: A miss whose block address matches a live fetch entry is merged into that entry's lowest free slot without a new request. A store merged before the request leaves turns that request exclusive. No two live entries ever share a block address.
- R4: `miss_stall` is high when: no entry matches and none is free; the matching entry has no free slot; a store matches an entry whose shared request has already left; the matching entry is draining or is a writeback; or `wb_valid` is high in the same cycle.
- R5: From the cycle after a fetch response is accepted, each valid slot is returned once per cycle, in fill order, on `cpu_valid`, with its instruction number and store flag. A load returns the word at its offset as updated by earlier stores in the entry. A store returns its own word.
- R6: The cycle after the last slot is returned, `fill_valid` presents the block address and the block with all stores merged, and the entry becomes free.
- R7: A writeback takes a free entry with its data and issues `req_kind` 2 carrying the block. Its response frees the entry and produces no `cpu_valid` or `fill_valid`.
- R8: `wb_stall` is high when no entry is free or when the writeback address matches a live entry.
- R9: `resp_ready` is low while an entry is draining.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Cache miss presented |
| miss_store | input | 1 | Miss is a store (1) or load (0) |
| miss_addr | input | ADDR_W | Block address of the miss |
| miss_off | input | OFF_W | Word offset within the block |
| miss_inum | input | INUM_W | Instruction number of the access |
| miss_wdata | input | WORD_W | Store word |
| miss_stall | output | 1 | Miss not accepted this cycle |
| wb_valid | input | 1 | Dirty eviction presented |
| wb_addr | input | ADDR_W | Block address of the eviction |
| wb_data | input | BLK_W | Evicted block |
| wb_stall | output | 1 | Eviction not accepted this cycle |
| req_valid | output | 1 | Request to the directory valid |
| req_kind | output | 2 | 0 shared, 1 exclusive, 2 writeback |
| req_addr | output | ADDR_W | Request block address |
| req_id | output | EW | Entry index carried by the request |
| req_data | output | BLK_W | Writeback block |
| req_ready | input | 1 | Request channel accepts |
| resp_valid | input | 1 | Response arrives |
| resp_id | input | EW | Entry the response belongs to |
| resp_data | input | BLK_W | Fetched block |
| resp_ready | output | 1 | Response can be taken |
| cpu_valid | output | 1 | One access retired |
| cpu_store | output | 1 | Retired access was a store |
| cpu_inum | output | INUM_W | Instruction number of retired access |
| cpu_data | output | WORD_W | Word loaded or stored |
| fill_valid | output | 1 | Merged block ready for the cache |
| fill_addr | output | ADDR_W | Fill block address |
| fill_data | output | BLK_W | Merged block |

## Verification
A load followed at once by a store to the same block probes the narrow window in which a merge and the request launch coincide. That test separates a request kind computed before the merge from one computed after it. The drain order is exposed by a load before and after a store to the same word, which shows whether stores are merged in slot order. A block filled to four slots, a full file and a store against an already-sent shared request each press one of the stall causes. A writeback pair, a same-cycle eviction and miss, and a stretch with the request channel held off separate writeback handling, eviction priority and request holding.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [1:0] {
    ENT_FREE  = 2'd0,
    ENT_PEND  = 2'd1,
    ENT_SENT  = 2'd2,
    ENT_DRAIN = 2'd3
  } ent_state_t;

  localparam logic [1:0] KIND_SH = 2'd0;
  localparam logic [1:0] KIND_EX = 2'd1;
  localparam logic [1:0] KIND_WB = 2'd2;
endpackage

// File: rtl/mshr_pick.sv
module mshr_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/mshr_lookup.sv
module mshr_lookup #(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 26
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] live,
  input  logic [ADDR_W-1:0]  tags [ENTRIES],
  input  logic [ADDR_W-1:0]  key,
  output logic [ENTRIES-1:0] match
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = live[g] && (tags[g] == key);
  end

  // R3: a block address lives in at most one entry
  assert_unique_tag_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));
endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int SLOTS   = 4,
  parameter int ADDR_W  = 26,
  parameter int WORDS   = 4,
  parameter int WORD_W  = 32,
  parameter int INUM_W  = 6,
  localparam int BLK_W  = WORDS * WORD_W,
  localparam int OFF_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int EW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic              miss_store,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [OFF_W-1:0]  miss_off,
  input  logic [INUM_W-1:0] miss_inum,
  input  logic [WORD_W-1:0] miss_wdata,
  output logic              miss_stall,
  input  logic              wb_valid,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [BLK_W-1:0]  wb_data,
  output logic              wb_stall,
  output logic              req_valid,
  output logic [1:0]        req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [EW-1:0]     req_id,
  output logic [BLK_W-1:0]  req_data,
  input  logic              req_ready,
  input  logic              resp_valid,
  input  logic [EW-1:0]     resp_id,
  input  logic [BLK_W-1:0]  resp_data,
  output logic              resp_ready,
  output logic              cpu_valid,
  output logic              cpu_store,
  output logic [INUM_W-1:0] cpu_inum,
  output logic [WORD_W-1:0] cpu_data,
  output logic              fill_valid,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [BLK_W-1:0]  fill_data
);
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  // entry control
  ent_state_t         st [ENTRIES];
  logic [ENTRIES-1:0] wbf, exf;
  logic [SLOTS-1:0]   sv  [ENTRIES];
  // entry datapath
  logic [ADDR_W-1:0]  tag   [ENTRIES];
  logic [BLK_W-1:0]   blk_q [ENTRIES];
  logic [SLOTS-1:0]   sst   [ENTRIES];
  logic [INUM_W-1:0]  sinum [ENTRIES][SLOTS];
  logic [OFF_W-1:0]   soff  [ENTRIES][SLOTS];
  logic [WORD_W-1:0]  swd   [ENTRIES][SLOTS];

  logic          drn_act;
  logic [EW-1:0] drn_ent;

  logic [ENTRIES-1:0] live, freev, pendv, m_match, w_match;
  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign live[e]  = (st[e] != ENT_FREE);
    assign freev[e] = (st[e] == ENT_FREE);
    assign pendv[e] = (st[e] == ENT_PEND);
  end

  mshr_lookup #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_miss_lu (
    .clk(clk), .rst(rst), .live(live), .tags(tag), .key(miss_addr), .match(m_match));
  mshr_lookup #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_wb_lu (
    .clk(clk), .rst(rst), .live(live), .tags(tag), .key(wb_addr), .match(w_match));

  logic m_hit, f_any, p_any, s_any, d_any;
  logic [EW-1:0] h_idx, f_idx, p_idx;
  logic [SW-1:0] s_idx, d_idx;

  mshr_pick #(.N(ENTRIES)) u_pick_hit  (.req(m_match), .any(m_hit), .idx(h_idx));
  mshr_pick #(.N(ENTRIES)) u_pick_free (.req(freev),   .any(f_any), .idx(f_idx));
  mshr_pick #(.N(ENTRIES)) u_pick_pend (.req(pendv),   .any(p_any), .idx(p_idx));
  mshr_pick #(.N(SLOTS))   u_pick_slot (.req(~sv[h_idx]),   .any(s_any), .idx(s_idx));
  mshr_pick #(.N(SLOTS))   u_pick_drn  (.req(sv[drn_ent]),  .any(d_any), .idx(d_idx));

  logic merge_ok, acc_new, acc_merge, acc_wb, resp_acc, req_load, ld_ex;
  ent_state_t hs;

  always_comb begin
    hs        = st[h_idx];
    merge_ok  = m_hit && !wbf[h_idx] && s_any &&
                (hs == ENT_PEND || (hs == ENT_SENT && (exf[h_idx] || !miss_store)));
    acc_new   = miss_valid && !wb_valid && !m_hit && f_any;
    acc_merge = miss_valid && !wb_valid && merge_ok;
    acc_wb    = wb_valid && !(|w_match) && f_any;
    resp_acc  = resp_valid && !drn_act;
    req_load  = !req_valid || req_ready;
    ld_ex     = exf[p_idx] || (acc_merge && miss_store && (h_idx == p_idx));
  end

  assign miss_stall = miss_valid && !(acc_new || acc_merge);
  assign wb_stall   = wb_valid && !acc_wb;
  assign resp_ready = !drn_act;

  // control path
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) begin
        st[e] <= ENT_FREE;
        sv[e] <= '0;
      end
      wbf        <= '0;
      exf        <= '0;
      req_valid  <= 1'b0;
      cpu_valid  <= 1'b0;
      fill_valid <= 1'b0;
      drn_act    <= 1'b0;
      drn_ent    <= '0;
    end else begin
      cpu_valid  <= 1'b0;
      fill_valid <= 1'b0;

      if (req_load) begin
        if (p_any) begin
          req_valid <= 1'b1;
          req_id    <= p_idx;
          req_addr  <= tag[p_idx];
          req_data  <= blk_q[p_idx];
          req_kind  <= wbf[p_idx] ? KIND_WB : (ld_ex ? KIND_EX : KIND_SH);
          st[p_idx] <= ENT_SENT;
        end else begin
          req_valid <= 1'b0;
        end
      end

      if (acc_new) begin
        st[f_idx]  <= ENT_PEND;
        wbf[f_idx] <= 1'b0;
        exf[f_idx] <= miss_store;
        sv[f_idx]  <= SLOTS'(1);
      end
      if (acc_merge) begin
        sv[h_idx][s_idx] <= 1'b1;
        if (miss_store) exf[h_idx] <= 1'b1;
      end
      if (acc_wb) begin
        st[f_idx]  <= ENT_PEND;
        wbf[f_idx] <= 1'b1;
        exf[f_idx] <= 1'b0;
        sv[f_idx]  <= '0;
      end

      if (resp_acc && st[resp_id] == ENT_SENT) begin
        if (wbf[resp_id]) begin
          st[resp_id] <= ENT_FREE;
        end else begin
          st[resp_id] <= ENT_DRAIN;
          drn_act     <= 1'b1;
          drn_ent     <= resp_id;
        end
      end

      if (drn_act) begin
        if (d_any) begin
          cpu_valid <= 1'b1;
          cpu_store <= sst[drn_ent][d_idx];
          cpu_inum  <= sinum[drn_ent][d_idx];
          cpu_data  <= sst[drn_ent][d_idx] ? swd[drn_ent][d_idx]
                       : blk_q[drn_ent][soff[drn_ent][d_idx]*WORD_W +: WORD_W];
          sv[drn_ent][d_idx] <= 1'b0;
        end else begin
          fill_valid  <= 1'b1;
          fill_addr   <= tag[drn_ent];
          fill_data   <= blk_q[drn_ent];
          st[drn_ent] <= ENT_FREE;
          drn_act     <= 1'b0;
        end
      end
    end
  end

  // data path: no reset, written only under the control path's accept terms
  always_ff @(posedge clk) begin
    if (acc_new) begin
      tag[f_idx]      <= miss_addr;
      sst[f_idx]      <= SLOTS'(miss_store);
      sinum[f_idx][0] <= miss_inum;
      soff[f_idx][0]  <= miss_off;
      swd[f_idx][0]   <= miss_wdata;
    end
    if (acc_merge) begin
      sst[h_idx][s_idx]   <= miss_store;
      sinum[h_idx][s_idx] <= miss_inum;
      soff[h_idx][s_idx]  <= miss_off;
      swd[h_idx][s_idx]   <= miss_wdata;
    end
    if (acc_wb) begin
      tag[f_idx]   <= wb_addr;
      blk_q[f_idx] <= wb_data;
    end
    if (resp_acc && st[resp_id] == ENT_SENT && !wbf[resp_id])
      blk_q[resp_id] <= resp_data;
    if (drn_act && d_any && sst[drn_ent][d_idx])
      blk_q[drn_ent][soff[drn_ent][d_idx]*WORD_W +: WORD_W] <= swd[drn_ent][d_idx];
  end

  // R2: a request waiting on the channel does not change
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_kind) && $stable(req_id));
  // R7: only the three defined request kinds appear
  assert_kind_legal_R7: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> req_kind != 2'd3);
  // R6: the fill closes a drain, no retirement follows immediately
  assert_fill_closes_R6: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> !cpu_valid);
  // R9: responses are refused while slots retire
  assert_busy_drain_R9: assert property (@(posedge clk) disable iff (rst)
    cpu_valid |-> !resp_ready);
  // R5: retirement and fill never overlap
  assert_one_output_R5: assert property (@(posedge clk) disable iff (rst)
    !(cpu_valid && fill_valid));
endmodule

// File: tb/test_mshr_file.sv
module test_mshr_file;
  localparam int AW = 26, WW = 32, NW = 4, BW = 128, IW = 6, OW = 2, EW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          miss_valid = 0, miss_store = 0;
  logic [AW-1:0] miss_addr = '0;
  logic [OW-1:0] miss_off = '0;
  logic [IW-1:0] miss_inum = '0;
  logic [WW-1:0] miss_wdata = '0;
  logic          miss_stall;
  logic          wb_valid = 0;
  logic [AW-1:0] wb_addr = '0;
  logic [BW-1:0] wb_data = '0;
  logic          wb_stall;
  logic          req_valid;
  logic [1:0]    req_kind;
  logic [AW-1:0] req_addr;
  logic [EW-1:0] req_id;
  logic [BW-1:0] req_data;
  logic          req_ready = 1;
  logic          resp_valid = 0;
  logic [EW-1:0] resp_id = '0;
  logic [BW-1:0] resp_data = '0;
  logic          resp_ready;
  logic          cpu_valid, cpu_store;
  logic [IW-1:0] cpu_inum;
  logic [WW-1:0] cpu_data;
  logic          fill_valid;
  logic [AW-1:0] fill_addr;
  logic [BW-1:0] fill_data;

  mshr_file i_mshr_file (.*);

  typedef struct packed { logic [1:0] k; logic [AW-1:0] a; logic [EW-1:0] id; logic [BW-1:0] d; } rq_t;
  typedef struct packed { logic s; logic [IW-1:0] n; logic [WW-1:0] d; } cp_t;
  typedef struct packed { logic [AW-1:0] a; logic [BW-1:0] d; } fl_t;
  rq_t rq_q[$];
  cp_t cp_q[$];
  fl_t fl_q[$];

  int nchk = 0, nbad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [BW-1:0] act, input logic [BW-1:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] blk(input logic [WW-1:0] base);
    logic [BW-1:0] b;
    for (int i = 0; i < NW; i++) b[i*WW +: WW] = base + WW'(i);
    return b;
  endfunction

  // monitor: compares design outputs against the scoreboard queues
  always @(negedge clk) begin
    if (!rst) begin
      if (req_valid && req_ready) begin
        if (rq_q.size() == 0) chk(0, "R2", "unexpected request", BW'(req_addr), '0);
        else begin
          rq_t e;
          e = rq_q.pop_front();
          chk(req_kind == e.k && req_addr == e.a && req_id == e.id &&
              (e.k != 2'd2 || req_data == e.d), (e.k == 2'd2) ? "R7" : "R2", "request",
              {req_kind, req_addr, req_id, req_data[63:0]}, {e.k, e.a, e.id, e.d[63:0]});
        end
      end
      if (cpu_valid) begin
        if (cp_q.size() == 0) chk(0, "R5", "unexpected retire", BW'(cpu_inum), '0);
        else begin
          cp_t c;
          c = cp_q.pop_front();
          chk(cpu_store == c.s && cpu_inum == c.n && cpu_data == c.d, "R5", "retire",
              BW'({cpu_store, cpu_inum, cpu_data}), BW'(c));
        end
      end
      if (fill_valid) begin
        if (fl_q.size() == 0) chk(0, "R6", "unexpected fill", BW'(fill_addr), '0);
        else begin
          fl_t f;
          f = fl_q.pop_front();
          chk(fill_addr == f.a && fill_data == f.d, "R6", "fill", fill_data, f.d);
        end
      end
    end
  end

  // drivers: called at posedge + 2, return at the next posedge + 2
  task automatic miss(input logic st, input logic [AW-1:0] a, input logic [OW-1:0] o,
                      input logic [IW-1:0] n, input logic [WW-1:0] wd,
                      input logic exp_stall, input string req);
    miss_valid = 1; miss_store = st; miss_addr = a; miss_off = o; miss_inum = n; miss_wdata = wd;
    #1 chk(miss_stall == exp_stall, req, "miss_stall", BW'(miss_stall), BW'(exp_stall));
    @(posedge clk); #2;
    miss_valid = 0;
  endtask

  task automatic wb(input logic [AW-1:0] a, input logic [BW-1:0] d,
                    input logic exp_stall, input string req);
    wb_valid = 1; wb_addr = a; wb_data = d;
    #1 chk(wb_stall == exp_stall, req, "wb_stall", BW'(wb_stall), BW'(exp_stall));
    @(posedge clk); #2;
    wb_valid = 0;
  endtask

  task automatic resp(input logic [EW-1:0] id, input logic [BW-1:0] d);
    resp_valid = 1; resp_id = id; resp_data = d;
    #1 chk(resp_ready == 1'b1, "R9", "resp_ready idle", BW'(resp_ready), BW'(1));
    @(posedge clk); #2;
    resp_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] da, db, dc, dd, de, dh, dh2, dj, dk, fa;
    da = blk(32'h1000); db = blk(32'h2000); dc = blk(32'h3000); dd = blk(32'h4000);
    de = blk(32'h5000); dh = blk(32'h7000); dh2 = blk(32'h8000); dj = blk(32'h9000);
    dk = blk(32'hA000);

    repeat (3) @(posedge clk);
    #2 rst = 0;
    #1;
    // R1 reset state
    chk(req_valid == 0, "R1", "req_valid", BW'(req_valid), '0);
    chk(cpu_valid == 0, "R1", "cpu_valid", BW'(cpu_valid), '0);
    chk(fill_valid == 0, "R1", "fill_valid", BW'(fill_valid), '0);
    chk(resp_ready == 1, "R1", "resp_ready", BW'(resp_ready), BW'(1));
    idle(1);

    // load, then store merged in the launch cycle -> exclusive request (R2, R3)
    rq_q.push_back('{2'd1, 26'h00A0, 2'd0, '0});
    miss(0, 26'h00A0, 2'd1, 6'd1, 32'h0, 0, "R2");
    miss(1, 26'h00A0, 2'd1, 6'd2, 32'hDEADBEEF, 0, "R3");
    miss(0, 26'h00A0, 2'd1, 6'd3, 32'h0, 0, "R3");
    idle(2);
    fa = da; fa[WW +: WW] = 32'hDEADBEEF;
    cp_q.push_back('{1'b0, 6'd1, 32'h1001});
    cp_q.push_back('{1'b1, 6'd2, 32'hDEADBEEF});
    cp_q.push_back('{1'b0, 6'd3, 32'hDEADBEEF});
    fl_q.push_back('{26'h00A0, fa});
    resp(0, da);
    idle(6);

    // shared entry B, stalls on late store and on full slots (R4)
    rq_q.push_back('{2'd0, 26'h00B0, 2'd0, '0});
    miss(0, 26'h00B0, 2'd0, 6'd4, 32'h0, 0, "R2");
    idle(3);
    miss(1, 26'h00B0, 2'd2, 6'd9, 32'h55, 1, "R4");
    miss(0, 26'h00B0, 2'd3, 6'd5, 32'h0, 0, "R3");
    miss(0, 26'h00B0, 2'd1, 6'd6, 32'h0, 0, "R3");
    miss(0, 26'h00B0, 2'd2, 6'd7, 32'h0, 0, "R3");
    miss(0, 26'h00B0, 2'd0, 6'd10, 32'h0, 1, "R4");

    // fill the file
    rq_q.push_back('{2'd0, 26'h00C0, 2'd1, '0});
    miss(0, 26'h00C0, 2'd2, 6'd11, 32'h0, 0, "R2");
    rq_q.push_back('{2'd0, 26'h00D0, 2'd2, '0});
    miss(0, 26'h00D0, 2'd0, 6'd12, 32'h0, 0, "R2");
    rq_q.push_back('{2'd0, 26'h00E0, 2'd3, '0});
    miss(0, 26'h00E0, 2'd3, 6'd13, 32'h0, 0, "R2");
    idle(3);
    miss(0, 26'h00F0, 2'd0, 6'd14, 32'h0, 1, "R4");
    wb(26'h0111, dh, 1, "R8");

    cp_q.push_back('{1'b0, 6'd11, 32'h3002});
    fl_q.push_back('{26'h00C0, dc});
    resp(1, dc);
    idle(4);

    cp_q.push_back('{1'b0, 6'd4, 32'h2000});
    cp_q.push_back('{1'b0, 6'd5, 32'h2003});
    cp_q.push_back('{1'b0, 6'd6, 32'h2001});
    cp_q.push_back('{1'b0, 6'd7, 32'h2002});
    fl_q.push_back('{26'h00B0, db});
    resp(0, db);
    chk(resp_ready == 0, "R9", "resp_ready draining", BW'(resp_ready), '0);
    idle(8);

    cp_q.push_back('{1'b0, 6'd12, 32'h4000});
    fl_q.push_back('{26'h00D0, dd});
    resp(2, dd);
    idle(4);
    cp_q.push_back('{1'b0, 6'd13, 32'h5003});
    fl_q.push_back('{26'h00E0, de});
    resp(3, de);
    idle(4);

    // writeback (R7, R8)
    rq_q.push_back('{2'd2, 26'h0123, 2'd0, dh});
    wb(26'h0123, dh, 0, "R7");
    idle(3);
    wb(26'h0123, dh, 1, "R8");
    miss(0, 26'h0123, 2'd0, 6'd20, 32'h0, 1, "R4");
    resp(0, '0);
    idle(3);
    rq_q.push_back('{2'd0, 26'h0123, 2'd0, '0});
    miss(0, 26'h0123, 2'd0, 6'd21, 32'h0, 0, "R7");
    idle(3);

    // eviction and miss together: eviction wins (R4, R8)
    rq_q.push_back('{2'd2, 26'h0200, 2'd1, dj});
    miss_valid = 1; miss_store = 0; miss_addr = 26'h0300; miss_off = 2'd1; miss_inum = 6'd22;
    wb_valid = 1; wb_addr = 26'h0200; wb_data = dj;
    #1;
    chk(miss_stall == 1, "R4", "miss_stall with eviction", BW'(miss_stall), BW'(1));
    chk(wb_stall == 0, "R8", "wb_stall with miss", BW'(wb_stall), '0);
    @(posedge clk); #2;
    miss_valid = 0; wb_valid = 0;
    idle(4);

    // channel held off (R2)
    req_ready = 0;
    rq_q.push_back('{2'd0, 26'h0300, 2'd2, '0});
    miss(0, 26'h0300, 2'd1, 6'd22, 32'h0, 0, "R2");
    idle(4);
    chk(req_valid == 1 && req_addr == 26'h0300 && req_kind == 2'd0, "R2", "held request",
        BW'({req_valid, req_kind, req_addr}), BW'({1'b1, 2'd0, 26'h0300}));
    req_ready = 1;
    idle(2);

    resp(1, '0);
    idle(2);
    cp_q.push_back('{1'b0, 6'd21, 32'h8000});
    fl_q.push_back('{26'h0123, dh2});
    resp(0, dh2);
    idle(5);
    cp_q.push_back('{1'b0, 6'd22, 32'hA001});
    fl_q.push_back('{26'h0300, dk});
    resp(2, dk);
    idle(6);

    chk(rq_q.size() == 0, "R2", "requests outstanding", BW'(rq_q.size()), '0);
    chk(cp_q.size() == 0, "R5", "retires outstanding", BW'(cp_q.size()), '0);
    chk(fl_q.size() == 0, "R6", "fills outstanding", BW'(fl_q.size()), '0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end
endmodule